// File: doc/BRIEF.md
# Memory Version Tag Checker

This block guards memory accesses on their way from a load/store unit to address translation. Each virtual address carries a small colour key in its top bits. For the addressed 64-byte granule, the block keeps a lock version in a local tag array. Every load and store is accepted through a valid/ready handshake. In the same cycle, the block looks up the lock and compares it with the key.

A matching or unchecked access goes out on a registered downstream port, with the key bits cleared. A mismatching access is dropped and reported as a one-cycle trap. The trap carries the full faulting address, the pointer key and the stored lock.

A separate tag-write port sets the lock of one granule. An allocator would use it when a buffer is handed out or released. When a tag write and an access hit the same granule in the same cycle, the access sees the new lock.

Top module: `mem_tag_checker`

## Requirements
- R1: The key is address bits [63:60]. The forwarded address equals the request address with bits [63:60] cleared and all lower bits unchanged.
- R2: The tag array holds one 4-bit lock per 64-byte granule, indexed by address bits [13:6]. Every byte offset of a granule (bits [5:0]) uses the same lock. The key bits are not part of the index.
- R3: When the lock is 1 to 13 and differs from the key, the access traps and is not forwarded. When the lock equals the key, the access is forwarded and does not trap.
- R4: A trap is signalled by trap_valid high for the single cycle after the access is accepted. In that cycle, trap_va holds the unmasked address, trap_key holds bits [63:60] of it, and trap_lock holds the lock that was compared.
- R5: When the lock is 0, 14 or 15, the access is forwarded and never traps, whatever the key.
- R6: After reset, every lock is 0, fwd_valid and trap_valid are low, and req_ready is high.
- R7: A tag write stores tag_ver as the lock of the granule that tag_va addresses, at the clock edge. An access accepted in the same cycle to the same granule is compared against the newly written version.
- R8: req_ready is high exactly when the output slot is empty or fwd_ready is high. While fwd_valid is high and fwd_ready is low, the forwarded fields stay unchanged.
- R9: Loads and stores are checked the same way, and fwd_is_store repeats the request's store flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Checker can take a request this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_va | input | 64 | Tagged virtual address |
| tag_wr_en | input | 1 | Write a granule lock |
| tag_va | input | 64 | Address selecting the granule to write |
| tag_ver | input | 4 | New lock version |
| fwd_valid | output | 1 | Checked access available downstream |
| fwd_ready | input | 1 | Downstream takes the access |
| fwd_is_store | output | 1 | Store flag of the forwarded access |
| fwd_addr | output | 64 | Address with the key bits cleared |
| trap_valid | output | 1 | One-cycle version mismatch report |
| trap_va | output | 64 | Faulting address, key included |
| trap_key | output | 4 | Key of the faulting pointer |
| trap_lock | output | 4 | Lock stored for the granule |

## Verification
The bench targets the lock boundaries 0, 1, 13, 14 and 15. A design with an off-by-one in the checked range would trap on a reserved lock or let a colour-13 overflow through. It also accesses the last byte of a granule and a neighbouring granule, which exposes a wrong index slice as a trap in the wrong place. A same-cycle write and access to one granule checks the write-first order: a read-first design would pass an access that should trap, and trap one that should pass. Downstream back-pressure runs together with random traffic, which catches a design that overwrites a stalled access or drops the key mask.

// File: rtl/mtc_pkg.sv
// Shared constants and helpers for the memory version tag checker.
// Assumes a 4-bit version field; locks 1..13 are checked, others bypass.
package mtc_pkg;
    localparam int KEY_W      = 4;
    localparam int LOCK_MIN   = 1;
    localparam int LOCK_MAX   = 13;

    typedef enum logic [1:0] {
        VERD_MATCH     = 2'd0,
        VERD_UNCHECKED = 2'd1,
        VERD_TRAP      = 2'd2
    } verdict_e;

    // True when a lock value takes part in comparison.
    function automatic logic lock_checked(input logic [KEY_W-1:0] lk);
        return (lk >= KEY_W'(LOCK_MIN)) && (lk <= KEY_W'(LOCK_MAX));
    endfunction
endpackage

// File: rtl/mtc_tag_store.sv
// Per-granule lock array built from flops so every entry clears on reset.
// Read is combinational with write-first bypass of a same-index write.
module mtc_tag_store
    import mtc_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_ver,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [KEY_W-1:0] rd_lock
);
    localparam int DEPTH = 1 << IDX_W;

    logic [KEY_W-1:0] locks [DEPTH];

    // Clear all locks on reset; store one lock on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                locks[i] <= '0;
            end
        end else if (wr_en) begin
            locks[wr_idx] <= wr_ver;
        end
    end

    // Read port: a write in flight to the same index wins.
    always_comb begin
        if (wr_en && (wr_idx == rd_idx)) begin
            rd_lock = wr_ver;
        end else begin
            rd_lock = locks[rd_idx];
        end
    end
endmodule

// File: rtl/mtc_compare.sv
// Splits a tagged address into key, granule index and masked address,
// and turns key plus lock into a verdict. Purely combinational.
module mtc_compare
    import mtc_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int GRAN_LG2 = 6,
    parameter int IDX_W    = 8
) (
    input  logic [VA_W-1:0]  va,
    input  logic [KEY_W-1:0] lock,
    output logic [KEY_W-1:0] key,
    output logic [IDX_W-1:0] idx,
    output logic [VA_W-1:0]  masked_va,
    output verdict_e         verdict
);
    localparam int KEY_LSB = VA_W - KEY_W;

    // Field extraction: key on top, index just above the granule offset.
    always_comb begin
        key       = va[VA_W-1:KEY_LSB];
        idx       = va[GRAN_LG2 +: IDX_W];
        masked_va = {{KEY_W{1'b0}}, va[KEY_LSB-1:0]};
    end

    // Decision: reserved locks bypass, checked locks must equal the key.
    always_comb begin
        if (!lock_checked(lock)) begin
            verdict = VERD_UNCHECKED;
        end else if (lock == key) begin
            verdict = VERD_MATCH;
        end else begin
            verdict = VERD_TRAP;
        end
    end
endmodule

// File: rtl/mtc_out_stage.sv
// Output register: holds one forwarded access under back-pressure and
// raises a one-cycle trap report for a rejected access.
// Assumes accept is only asserted while slot_free is high.
module mtc_out_stage
    import mtc_pkg::*;
#(
    parameter int VA_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  verdict_e         verdict,
    input  logic             is_store,
    input  logic [VA_W-1:0]  masked_va,
    input  logic [VA_W-1:0]  raw_va,
    input  logic [KEY_W-1:0] key,
    input  logic [KEY_W-1:0] lock,
    input  logic             fwd_ready,
    output logic             slot_free,
    output logic             fwd_valid,
    output logic             fwd_is_store,
    output logic [VA_W-1:0]  fwd_addr,
    output logic             trap_valid,
    output logic [VA_W-1:0]  trap_va,
    output logic [KEY_W-1:0] trap_key,
    output logic [KEY_W-1:0] trap_lock
);
    logic is_trap;

    // Slot can take a new access if empty or being drained now.
    always_comb begin
        slot_free = !fwd_valid || fwd_ready;
        is_trap   = (verdict == VERD_TRAP);
    end

    // Forward slot: load on a passing accept, clear when drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid    <= 1'b0;
            fwd_is_store <= 1'b0;
            fwd_addr     <= '0;
        end else if (accept && !is_trap) begin
            fwd_valid    <= 1'b1;
            fwd_is_store <= is_store;
            fwd_addr     <= masked_va;
        end else if (fwd_ready) begin
            fwd_valid    <= 1'b0;
        end
    end

    // Trap report: pulse for one cycle, fields captured with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_valid <= 1'b0;
            trap_va    <= '0;
            trap_key   <= '0;
            trap_lock  <= '0;
        end else begin
            trap_valid <= accept && is_trap;
            if (accept && is_trap) begin
                trap_va   <= raw_va;
                trap_key  <= key;
                trap_lock <= lock;
            end
        end
    end

    // R1: nothing leaves with key bits set.
    p_fwd_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (fwd_addr[VA_W-1 -: KEY_W] == '0));

    // R3: a trapped access never occupies the forward slot.
    p_trap_no_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> !fwd_valid);

    // R4: reported key is the top field of the reported address.
    p_trap_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (trap_key == trap_va[VA_W-1 -: KEY_W]));

    // R5: a trap only ever reports a checked lock that differs from the key.
    p_trap_checked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (lock_checked(trap_lock) && (trap_lock != trap_key)));

    // R8: a stalled access stays put.
    p_fwd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_addr)
                                       && $stable(fwd_is_store)));
endmodule

// File: rtl/mem_tag_checker.sv
// Top level: accepts tagged accesses, looks up the granule lock, checks
// it against the pointer key, forwards masked addresses or reports traps.
// Assumes VA_W - KEY_W >= GRAN_LG2 + IDX_W.
module mem_tag_checker
    import mtc_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int GRAN_LG2 = 6,
    parameter int IDX_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_is_store,
    input  logic [VA_W-1:0]  req_va,
    input  logic             tag_wr_en,
    input  logic [VA_W-1:0]  tag_va,
    input  logic [KEY_W-1:0] tag_ver,
    output logic             fwd_valid,
    input  logic             fwd_ready,
    output logic             fwd_is_store,
    output logic [VA_W-1:0]  fwd_addr,
    output logic             trap_valid,
    output logic [VA_W-1:0]  trap_va,
    output logic [KEY_W-1:0] trap_key,
    output logic [KEY_W-1:0] trap_lock
);
    logic [KEY_W-1:0] key;
    logic [KEY_W-1:0] lock;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    logic [VA_W-1:0]  masked_va;
    verdict_e         verdict;
    logic             slot_free;
    logic             accept;

    // Handshake and tag-write index.
    always_comb begin
        req_ready = slot_free;
        accept    = req_valid && slot_free;
        wr_idx    = tag_va[GRAN_LG2 +: IDX_W];
    end

    mtc_compare #(.VA_W(VA_W), .GRAN_LG2(GRAN_LG2), .IDX_W(IDX_W)) u_cmp (
        .va        (req_va),
        .lock      (lock),
        .key       (key),
        .idx       (rd_idx),
        .masked_va (masked_va),
        .verdict   (verdict)
    );

    mtc_tag_store #(.IDX_W(IDX_W)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tag_wr_en),
        .wr_idx  (wr_idx),
        .wr_ver  (tag_ver),
        .rd_idx  (rd_idx),
        .rd_lock (lock)
    );

    mtc_out_stage #(.VA_W(VA_W)) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .verdict      (verdict),
        .is_store     (req_is_store),
        .masked_va    (masked_va),
        .raw_va       (req_va),
        .key          (key),
        .lock         (lock),
        .fwd_ready    (fwd_ready),
        .slot_free    (slot_free),
        .fwd_valid    (fwd_valid),
        .fwd_is_store (fwd_is_store),
        .fwd_addr     (fwd_addr),
        .trap_valid   (trap_valid),
        .trap_va      (trap_va),
        .trap_key     (trap_key),
        .trap_lock    (trap_lock)
    );

    // R7: a same-granule write forces the compared lock to the new version.
    p_write_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_wr_en && req_valid && (wr_idx == rd_idx)) |-> (lock == tag_ver));
endmodule

// File: tb/mem_tag_checker_test.sv
// Bench: behavioural reference model compared every cycle, plus directed
// corner cases with named checks.
module mem_tag_checker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_is_store = 1'b0;
    logic [63:0] req_va = '0;
    logic        tag_wr_en = 1'b0;
    logic [63:0] tag_va = '0;
    logic [3:0]  tag_ver = '0;
    logic        fwd_valid;
    logic        fwd_ready = 1'b1;
    logic        fwd_is_store;
    logic [63:0] fwd_addr;
    logic        trap_valid;
    logic [63:0] trap_va;
    logic [3:0]  trap_key;
    logic [3:0]  trap_lock;

    int checks = 0;
    int fails  = 0;
    bit started = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mem_tag_checker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_is_store(req_is_store), .req_va(req_va), .tag_wr_en(tag_wr_en),
        .tag_va(tag_va), .tag_ver(tag_ver), .fwd_valid(fwd_valid),
        .fwd_ready(fwd_ready), .fwd_is_store(fwd_is_store), .fwd_addr(fwd_addr),
        .trap_valid(trap_valid), .trap_va(trap_va), .trap_key(trap_key),
        .trap_lock(trap_lock)
    );

    // Reference model state.
    int          m_tags [256];
    bit          m_fwd_v;
    bit          m_fwd_s;
    logic [63:0] m_fwd_a;
    bit          m_trap_v;
    logic [63:0] m_trap_va;
    int          m_trap_key;
    int          m_trap_lock;

    function automatic int gidx(input logic [63:0] a);
        return int'((a >> 6) & 64'hFF);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Model update at each rising edge from the bench-driven inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_tags[i]) m_tags[i] = 0;
            m_fwd_v = 0; m_fwd_s = 0; m_fwd_a = '0; m_trap_v = 0;
            started = 1;
        end else begin
            bit ready;
            bit acc;
            int lk;
            int ky;
            ready = !m_fwd_v || fwd_ready;
            acc = req_valid && ready;
            lk = (tag_wr_en && gidx(tag_va) == gidx(req_va)) ? int'(tag_ver)
                                                              : m_tags[gidx(req_va)];
            ky = int'(req_va[63:60]);
            if (tag_wr_en) m_tags[gidx(tag_va)] = int'(tag_ver);
            if (m_fwd_v && fwd_ready) m_fwd_v = 0;
            m_trap_v = 0;
            if (acc) begin
                if (lk >= 1 && lk <= 13 && lk != ky) begin
                    m_trap_v = 1; m_trap_va = req_va;
                    m_trap_key = ky; m_trap_lock = lk;
                end else begin
                    m_fwd_v = 1; m_fwd_s = req_is_store;
                    m_fwd_a = {4'h0, req_va[59:0]};
                end
            end
        end
    end

    // Cycle compare at the falling edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk(fwd_valid == m_fwd_v, "R3", "fwd_valid", 64'(fwd_valid), 64'(m_fwd_v));
            chk(trap_valid == m_trap_v, "R3", "trap_valid", 64'(trap_valid), 64'(m_trap_v));
            chk(req_ready == (!m_fwd_v || fwd_ready), "R8", "req_ready",
                64'(req_ready), 64'(!m_fwd_v || fwd_ready));
            if (m_fwd_v && fwd_valid) begin
                chk(fwd_addr == m_fwd_a, "R1", "fwd_addr", fwd_addr, m_fwd_a);
                chk(fwd_is_store == m_fwd_s, "R9", "fwd_is_store",
                    64'(fwd_is_store), 64'(m_fwd_s));
            end
            if (m_trap_v && trap_valid) begin
                chk(trap_va == m_trap_va, "R4", "trap_va", trap_va, m_trap_va);
                chk(int'(trap_key) == m_trap_key, "R4", "trap_key",
                    64'(trap_key), 64'(m_trap_key));
                chk(int'(trap_lock) == m_trap_lock, "R4", "trap_lock",
                    64'(trap_lock), 64'(m_trap_lock));
            end
        end
    end

    function automatic logic [63:0] mk(input int key, input int gran, input int off);
        return {4'(key), 60'(gran * 64 + off)};
    endfunction

    // Write one lock on its own.
    task automatic wr_tag(input int gran, input int ver);
        @(negedge clk); #1;
        tag_wr_en = 1; tag_va = mk(0, gran, 0); tag_ver = 4'(ver);
        @(negedge clk); #1;
        tag_wr_en = 0;
    endtask

    // One access (slot free assumed), optional same-cycle tag write.
    task automatic do_access(input logic [63:0] va, input bit st, input bit wen,
                             input int wgran, input int wver, input bit exp_trap,
                             input string req);
        @(negedge clk); #1;
        req_valid = 1; req_va = va; req_is_store = st;
        tag_wr_en = wen; tag_va = mk(0, wgran, 0); tag_ver = 4'(wver);
        @(negedge clk); #2;
        chk(trap_valid == exp_trap, req, "trap outcome", 64'(trap_valid), 64'(exp_trap));
        chk(fwd_valid == !exp_trap, req, "forward outcome", 64'(fwd_valid), 64'(!exp_trap));
        req_valid = 0; tag_wr_en = 0;
    endtask

    initial begin
        #(8 * 100000);
        fails++; checks++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'd1, 64'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        @(negedge clk); #2;
        // R6: reset state
        chk(!fwd_valid && !trap_valid, "R6", "outputs idle",
            64'({fwd_valid, trap_valid}), 64'd0);
        chk(req_ready == 1, "R6", "req_ready", 64'(req_ready), 64'd1);
        do_access(mk(5, 3, 8), 0, 0, 0, 0, 0, "R6");     // lock 0 after reset
        wr_tag(3, 7);
        do_access(mk(7, 3, 0), 0, 0, 0, 0, 0, "R3");     // match
        do_access(mk(9, 3, 0), 0, 0, 0, 0, 1, "R3");     // mismatch
        do_access(mk(9, 3, 63), 1, 0, 0, 0, 1, "R2");    // last byte, same lock
        do_access(mk(7, 3, 63), 0, 0, 0, 0, 0, "R2");
        do_access(mk(9, 4, 0), 0, 0, 0, 0, 0, "R2");     // neighbour unlocked
        do_access(mk(9, 3 + 256, 0), 0, 0, 0, 0, 1, "R2"); // index wraps at bit 14
        wr_tag(4, 14);
        do_access(mk(3, 4, 4), 0, 0, 0, 0, 0, "R5");
        wr_tag(4, 15);
        do_access(mk(0, 4, 4), 1, 0, 0, 0, 0, "R5");
        wr_tag(4, 0);
        do_access(mk(12, 4, 4), 0, 0, 0, 0, 0, "R5");
        wr_tag(5, 13);
        do_access(mk(13, 5, 1), 0, 0, 0, 0, 0, "R3");
        do_access(mk(12, 5, 1), 1, 0, 0, 0, 1, "R9");    // store mismatch
        wr_tag(6, 1);
        do_access(mk(0, 6, 2), 0, 0, 0, 0, 1, "R3");
        do_access(mk(14, 6, 2), 0, 0, 0, 0, 1, "R3");
        // R7: write-first on same granule
        do_access(mk(6, 7, 0), 0, 1, 7, 2, 1, "R7");
        do_access(mk(6, 7, 0), 0, 1, 7, 6, 0, "R7");
        do_access(mk(6, 7, 0), 0, 1, 8, 3, 0, "R7");     // other granule written
        // R8: back-pressure
        @(negedge clk); #1 fwd_ready = 0;
        do_access(mk(6, 7, 16), 0, 0, 0, 0, 0, "R8");
        #1 req_valid = 1; req_va = mk(1, 9, 0);
        repeat (3) begin
            @(negedge clk); #2;
            chk(req_ready == 0 && fwd_valid == 1, "R8", "stalled",
                64'({req_ready, fwd_valid}), 64'b01);
            chk(fwd_addr == mk(0, 7, 16), "R8", "held addr", fwd_addr, mk(0, 7, 16));
        end
        #1 fwd_ready = 1;
        @(negedge clk); #1 req_valid = 0;
        // Random traffic checked by the model.
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk); #1;
            req_valid = $urandom_range(0, 1);
            req_is_store = $urandom_range(0, 1);
            req_va = mk($urandom_range(0, 15), $urandom_range(0, 7),
                        $urandom_range(0, 63)) | {4'h0, 28'($urandom), 32'h0};
            tag_wr_en = ($urandom_range(0, 3) == 0);
            tag_va = mk($urandom_range(0, 15), $urandom_range(0, 7), 0);
            tag_ver = 4'($urandom_range(0, 15));
            fwd_ready = ($urandom_range(0, 3) != 0);
        end
        @(negedge clk); #1;
        req_valid = 0; tag_wr_en = 0; fwd_ready = 1;
        repeat (3) @(negedge clk);
        #3 done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule